// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two channel signals of an incremental encoder into a position count. Both channels are brought into the system clock domain by multi-flop synchronisers. The block then compares each synchronised sample with the one before it and derives count events and a direction. A two-bit source field picks one of four ways of counting:

- full-resolution quadrature, which counts every edge of both channels;
- pulse with direction, where rising edges of A count and the level of B gives the direction;
- count up on A only;
- count down on A only.

In the two single-channel modes, a qualifier bit chooses between counting rising edges only and counting both edges.

The count runs between zero and a programmable maximum. Counting up from the maximum wraps to zero, and counting down from zero wraps to the maximum. Software uses a small word-addressed register port to:

- read the count and load it, where a load above the maximum is refused;
- set the maximum;
- pick the count source and edge qualifier;
- start and stop counting.

Top module: `qep_counter`

## Requirements
- R1: After reset the count reads 0, the maximum reads all ones (0xFFFFFFFF), and the decoder-control and module-control words read 0.
- R2: With source 0 (quadrature), each single-bit change of the synchronised (A,B) pair moves the count by one. Stepping through AB = 00, 01, 11, 10, 00 counts up, and the reverse order counts down.
- R3: With source 0, a change in which A and B both toggle between two samples leaves the count unchanged.
- R4: With source 1 (pulse with direction), only a rising edge of A counts. It counts up when B is 1 and down when B is 0. Falling edges of A and any change of B alone leave the count unchanged.
- R5: With source 2 (up-count), B has no effect. Decoder-control bit 11 = 0 counts rising edges of A, and bit 11 = 1 counts both edges of A, each event adding one.
- R6: With source 3 (down-count), events are chosen as in R5, but each one subtracts one.
- R7: An up event at a count equal to (or above) the maximum gives 0. A down event at count 0 gives the maximum.
- R8: A write to the count register with a value greater than the maximum is refused, and the count keeps its value in that cycle. A value at or below the maximum is loaded.
- R9: When module-control bit 3 is 0, no count events are applied.
- R10: Register offsets are as follows, and any other offset reads 0:
  - 0x00: count (32-bit).
  - 0x08: maximum (32-bit).
  - 0x28: decoder-control, with the source in bits 15:14, the edge qualifier in bit 11, and other bits reading 0.
  - 0x2A: module-control, with the enable in bit 3 and other bits reading 0.
- R11: A change on an encoder input made before a clock edge shows in the count after the third rising clock edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enc_a | input | 1 | Encoder channel A, asynchronous |
| enc_b | input | 1 | Encoder channel B, asynchronous |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |

## Verification
The hardest situations to reach from the ports are the transitions that matter only in one mode, meeting a wrap boundary. Examples are a falling A edge in pulse mode, a double toggle in quadrature, and a down event at zero. Free-running encoder waveforms visit these rarely. The bench therefore uses a small maximum of 5 and, for every source and qualifier setting (and again with the counter stopped), drives a sequence that covers all sixteen ordered (A,B) state pairs. After each step it compares the count with an arithmetic model. Because the maximum is small, the count crosses both wrap points many times during each sweep.

// File: rtl/qep_pkg.sv
// Shared definitions for the quadrature encoder position counter:
// count-source encoding, register offsets and control bit positions.
package qep_pkg;

    typedef enum logic [1:0] {
        SRC_QUAD     = 2'd0,
        SRC_PULSEDIR = 2'd1,
        SRC_UPONLY   = 2'd2,
        SRC_DOWNONLY = 2'd3
    } cnt_src_e;

    localparam int OFS_POS    = 'h00;
    localparam int OFS_LIMIT  = 'h08;
    localparam int OFS_DECODE = 'h28;
    localparam int OFS_MODE   = 'h2A;

    localparam int SRC_LSB       = 14;
    localparam int BOTHEDGE_BIT  = 11;
    localparam int RUN_BIT       = 3;

endpackage

// File: rtl/qep_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous inputs.
// Assumes STAGES >= 2; all stages clear on reset.
module qep_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] pipe_q;

    // Shift the raw inputs through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], din};
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/qep_decode.sv
// Edge qualification and direction decode. Compares the synchronised
// (A,B) pair with the previous sample and raises at most one of
// step_up / step_dn per cycle according to the selected count source.
// Assumes a and b are already in the clk domain.
module qep_decode
    import qep_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     a,
    input  logic     b,
    input  cnt_src_e src,
    input  logic     both_edges,
    output logic     step_up,
    output logic     step_dn
);
    logic prev_a, prev_b;
    logic a_rise, a_chg, b_chg;

    // Remember the previous synchronised sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_a <= 1'b0;
            prev_b <= 1'b0;
        end else begin
            prev_a <= a;
            prev_b <= b;
        end
    end

    assign a_rise = a & ~prev_a;
    assign a_chg  = a ^ prev_a;
    assign b_chg  = b ^ prev_b;

    // Turn the sample pair into a count event for the active source.
    always_comb begin
        step_up = 1'b0;
        step_dn = 1'b0;
        unique case (src)
            SRC_QUAD: begin
                if (a_chg ^ b_chg) begin
                    if (prev_a ^ b) step_up = 1'b1;
                    else            step_dn = 1'b1;
                end
            end
            SRC_PULSEDIR: begin
                if (a_rise) begin
                    if (b) step_up = 1'b1;
                    else   step_dn = 1'b1;
                end
            end
            SRC_UPONLY:   step_up = both_edges ? a_chg : a_rise;
            SRC_DOWNONLY: step_dn = both_edges ? a_chg : a_rise;
            default: ;
        endcase
    end
endmodule

// File: rtl/qep_position.sv
// Position count and maximum registers. Applies count events with wrap
// at the maximum and at zero, and loads the count from the register port
// only when the value does not exceed the maximum. A load cycle, accepted
// or not, takes priority over a count event.
module qep_position #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic              wr_pos,
    input  logic              wr_limit,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pos,
    output logic [DATA_W-1:0] limit
);
    // Maximum register: reset to all ones, written from the port.
    always_ff @(posedge clk) begin
        if (!rst_n)        limit <= '1;
        else if (wr_limit) limit <= wdata;
    end

    // Position count: range-checked load, else wrapped counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (wr_pos) begin
            if (wdata <= limit) pos <= wdata;
        end else if (run) begin
            if (step_up)      pos <= (pos >= limit) ? '0 : pos + 1'b1;
            else if (step_dn) pos <= (pos == '0) ? limit : pos - 1'b1;
        end
    end
endmodule

// File: rtl/qep_counter.sv
// Top of the quadrature encoder position counter. Synchronises the two
// encoder channels, decodes count events, keeps the position and holds
// the decoder-control and module-control words behind a simple register
// port (single-cycle write strobe, combinational read). Assumes DATA_W >= 16.
module qep_counter
    import qep_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enc_a,
    input  logic              enc_b,
    input  logic              reg_wen,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_POS    = ADDR_W'(OFS_POS);
    localparam logic [ADDR_W-1:0] A_LIMIT  = ADDR_W'(OFS_LIMIT);
    localparam logic [ADDR_W-1:0] A_DECODE = ADDR_W'(OFS_DECODE);
    localparam logic [ADDR_W-1:0] A_MODE   = ADDR_W'(OFS_MODE);

    logic [1:0]        ab_sync;
    cnt_src_e          src_q;
    logic              both_q, run_q;
    logic              step_up, step_dn;
    logic              wr_pos, wr_limit, wr_decode, wr_mode;
    logic [DATA_W-1:0] pos_q, limit_q;

    assign wr_pos    = reg_wen && (reg_addr == A_POS);
    assign wr_limit  = reg_wen && (reg_addr == A_LIMIT);
    assign wr_decode = reg_wen && (reg_addr == A_DECODE);
    assign wr_mode   = reg_wen && (reg_addr == A_MODE);

    qep_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({enc_a, enc_b}),
        .dout  (ab_sync)
    );

    // Decoder-control and module-control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= SRC_QUAD;
            both_q <= 1'b0;
            run_q  <= 1'b0;
        end else begin
            if (wr_decode) begin
                src_q  <= cnt_src_e'(reg_wdata[SRC_LSB+1:SRC_LSB]);
                both_q <= reg_wdata[BOTHEDGE_BIT];
            end
            if (wr_mode) run_q <= reg_wdata[RUN_BIT];
        end
    end

    qep_decode u_decode (
        .clk        (clk),
        .rst_n      (rst_n),
        .a          (ab_sync[1]),
        .b          (ab_sync[0]),
        .src        (src_q),
        .both_edges (both_q),
        .step_up    (step_up),
        .step_dn    (step_dn)
    );

    qep_position #(.DATA_W(DATA_W)) u_position (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_q),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .wr_pos   (wr_pos),
        .wr_limit (wr_limit),
        .wdata    (reg_wdata),
        .pos      (pos_q),
        .limit    (limit_q)
    );

    // Read multiplexer; unused bits and offsets read as zero.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_POS:    reg_rdata = pos_q;
            A_LIMIT:  reg_rdata = limit_q;
            A_DECODE: begin
                reg_rdata[SRC_LSB+1:SRC_LSB] = src_q;
                reg_rdata[BOTHEDGE_BIT]      = both_q;
            end
            A_MODE:   reg_rdata[RUN_BIT] = run_q;
            default:  ;
        endcase
    end
endmodule

// File: rtl/qep_counter_chk.sv
// Property checker for qep_counter, attached by bind. Relates the count
// events from the decoder to the position and maximum registers.
module qep_counter_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run,
    input logic              step_up,
    input logic              step_dn,
    input logic              wr_pos,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] pos,
    input logic [DATA_W-1:0] limit
);
    p_one_direction_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({step_up, step_dn}));

    p_wrap_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_pos && step_up && pos == limit) |=> (pos == '0));

    p_wrap_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wr_pos && step_dn && pos == '0) |=> (pos == $past(limit)));

    p_refuse_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pos && wdata > limit) |=> $stable(pos));

    p_accept_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pos && wdata <= limit) |=> (pos == $past(wdata)));

    p_stopped_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_pos) |=> $stable(pos));
endmodule

bind qep_counter qep_counter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .step_up (step_up),
    .step_dn (step_dn),
    .wr_pos  (wr_pos),
    .wdata   (reg_wdata),
    .pos     (pos_q),
    .limit   (limit_q)
);

// File: tb/test_qep_counter.sv
module test_qep_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enc_a = 1'b0, enc_b = 1'b0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    // model state
    logic [31:0] m_pos = '0, m_lim = '1;
    logic [1:0]  m_src = 2'd0;
    logic        m_both = 1'b0, m_run = 1'b0;
    logic        pa = 1'b0, pb = 1'b0;

    always #2.5 clk = ~clk;

    qep_counter i_qep_counter (
        .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
        .reg_wen(reg_wen), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] addr, output logic [31:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [31:0] data);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = addr; reg_wdata = data;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic set_decode(input logic [1:0] src, input logic both);
        wr(8'h28, {16'h0, src, 2'b00, both, 11'h0});
        m_src = src; m_both = both;
    endtask

    // expected event direction from the requirements: +1, -1 or 0
    function automatic int model_ev(input logic na, input logic nb);
        case (m_src)
            2'd0: if ((na ^ pa) ^ (nb ^ pb)) return (pa ^ nb) ? 1 : -1;
            2'd1: if (na && !pa) return nb ? 1 : -1;
            2'd2: if (m_both ? (na != pa) : (na && !pa)) return 1;
            default: if (m_both ? (na != pa) : (na && !pa)) return -1;
        endcase
        return 0;
    endfunction

    task automatic drive(input logic [1:0] ab, input string tag);
        logic [31:0] got;
        int d;
        d = model_ev(ab[1], ab[0]);
        if (m_run && d == 1)  m_pos = (m_pos >= m_lim) ? 32'd0 : m_pos + 1;
        if (m_run && d == -1) m_pos = (m_pos == 0) ? m_lim : m_pos - 1;
        pa = ab[1]; pb = ab[0];
        @(negedge clk);
        {enc_a, enc_b} = ab;
        repeat (3) @(negedge clk);
        rd(8'h00, got);
        chk(tag, got, m_pos);
    endtask

    task automatic sweep(input string tag);
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++) begin
                drive(2'(i), tag);
                drive(2'(j), tag);
            end
    endtask

    initial begin
        #500000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        string tags [4];
        tags[0] = "R2/R3 quadrature";
        tags[1] = "R4 pulse-direction";
        tags[2] = "R5 up-count";
        tags[3] = "R6 down-count";

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, v); chk("R1 count", v, 32'h0);
        rd(8'h08, v); chk("R1 maximum", v, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R1 decoder-control", v, 32'h0);
        rd(8'h2A, v); chk("R1 module-control", v, 32'h0);

        // R10 register map
        wr(8'h08, 32'd5); m_lim = 32'd5;
        rd(8'h08, v); chk("R10 maximum", v, 32'd5);
        wr(8'h2A, 32'hFFFF); m_run = 1'b1;
        rd(8'h2A, v); chk("R10 module-control", v, 32'h8);
        wr(8'h28, 32'hFFFF);
        rd(8'h28, v); chk("R10 decoder-control", v, 32'hC800);
        rd(8'h04, v); chk("R10 unused offset", v, 32'h0);
        set_decode(2'd0, 1'b0);

        // R11 latency: B rises from AB=00 in quadrature -> +1
        @(negedge clk); enc_b = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h00, v); chk("R11 not after second edge", v, 32'd0);
        @(negedge clk);
        rd(8'h00, v); chk("R11 after third edge", v, 32'd1);
        m_pos = 32'd1; pa = 1'b0; pb = 1'b1;

        // R7 explicit wraps
        drive(2'b11, "R2 up"); drive(2'b10, "R2 up"); drive(2'b00, "R2 up");
        drive(2'b01, "R2 up");
        drive(2'b11, "R7 wrap up to 0");
        drive(2'b01, "R7 wrap down to max");
        drive(2'b00, "R2 down");

        // R2..R6: all ordered state pairs for every source and qualifier
        for (int s = 0; s < 4; s++)
            for (int e = 0; e < 2; e++) begin
                set_decode(2'(s), e[0]);
                sweep(tags[s]);
            end

        // R9: counter stopped
        wr(8'h2A, 32'h0); m_run = 1'b0;
        set_decode(2'd0, 1'b0); sweep("R9 stopped quadrature");
        set_decode(2'd2, 1'b1); sweep("R9 stopped up-count");
        wr(8'h2A, 32'h8); m_run = 1'b1;

        // R8 range-checked load
        wr(8'h00, 32'd3); m_pos = 32'd3;
        rd(8'h00, v); chk("R8 accepted load", v, 32'd3);
        wr(8'h00, 32'd6);
        rd(8'h00, v); chk("R8 refused load", v, 32'd3);
        wr(8'h00, 32'd5); m_pos = 32'd5;
        rd(8'h00, v); chk("R8 load at maximum", v, 32'd5);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, v); chk("R8 refused all ones", v, 32'd5);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule